// File: doc/BRIEF.md
# Eight-Tone Recursive DFT Bank

This block evaluates the discrete Fourier transform at eight fixed bin indices, one for each of the eight touch-tone frequencies. It does this with a second-order resonator per bin instead of a full transform. A block is N real samples long, and each sample arrives with a one-cycle strobe. Every accepted sample advances all eight resonators at once. A resonator keeps two state words, and the block clears them at the start of every frame.

After the N-th sample, the block spends two cycles forming the complex result of each bin. The first cycle forms the real part and the second forms the imaginary part. In both cycles the bin's single real multiplier is reused. The results of all eight bins then appear together with a one-cycle done pulse, and they hold until the next pulse. A downstream magnitude and peak picker uses the results to decide which key was pressed.

Top module: `rdft_dtmf_bank`

## Requirements
- R1: While reset is high and after it is released, done is 0 and every result output is 0 until the first frame completes.
- R2: Bin i (0..7) serves tone f_i: 697, 770, 852, 941, 1209, 1336, 1477, 1633 Hz in that order. Its index is k = round(f_i·N/8000) and its angle is θ = 2πk/N. Its coefficients are C = round(cos θ·2^14) and S = round(sin θ·2^14), each a 16-bit signed value.
- R3: On each strobe accepted in the run phase, each bin computes p = C·s1 exactly. Its new state is s = x + (p >>> 13) − s2, kept to SW bits signed by two's-complement wrap, with s2 taking the old s1. Here >>> is an arithmetic shift that rounds toward minus infinity.
- R4: For a frame, s1 and s2 are the states after the N-th accepted sample. Bin i reports Re = ((C·s1) >>> 14) − s2 and Im = (S·s1) >>> 14, each SW bits signed. They appear on re_o and im_o in bits [i·SW +: SW].
- R5: Done is high for exactly one cycle. It rises on the second clock edge after the edge that accepts the N-th sample of a frame.
- R6: re_o and im_o change only on the edge that raises done, and they hold their values in all other cycles.
- R7: A strobe seen on either of the two edges after the N-th sample is ignored: it neither enters the state nor counts as a sample.
- R8: Each frame starts from zero state. A strobe on the edge at the end of the done cycle is the first sample of the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | XW | Signed input sample |
| re_o | output | 8·SW | Real parts, bin i at [i·SW +: SW] |
| im_o | output | 8·SW | Imaginary parts, bin i at [i·SW +: SW] |
| done_o | output | 1 | One-cycle result pulse |

## Verification
The bench builds the block with its default values: N = 256, 12-bit samples and 24-bit state. As a result, the bin indices, coefficients and frame length match the real tone-detection setting, and full-scale DC, impulse, alternating and two-tone frames show whether the state width is enough. With the full frame length, the counter wraps at its top value, so a miscount of one sample changes every bin. Back-to-back frames, with stray strobes in both finishing cycles, reach the ignore and restart rules.

// File: rtl/rdft_dtmf_pkg.sv
package rdft_dtmf_pkg;

    localparam int NUM_BINS  = 8;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int FS_HZ     = 8000;

    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_FIN_RE = 2'd1,
        PH_FIN_IM = 2'd2
    } phase_e;

    // bin order: low group ascending, then high group ascending
    function automatic int tone_hz(input int idx);
        case (idx)
            0: return 697;
            1: return 770;
            2: return 852;
            3: return 941;
            4: return 1209;
            5: return 1336;
            6: return 1477;
            default: return 1633;
        endcase
    endfunction

    function automatic int bin_index(input int idx, input int n);
        return int'(real'(tone_hz(idx)) * real'(n) / real'(FS_HZ));
    endfunction

    function automatic int cos_q(input int k, input int n);
        return int'($cos(2.0 * 3.14159265358979 * real'(k) / real'(n)) * real'(1 << COEF_FRAC));
    endfunction

    function automatic int sin_q(input int k, input int n);
        return int'($sin(2.0 * 3.14159265358979 * real'(k) / real'(n)) * real'(1 << COEF_FRAC));
    endfunction

endpackage

// File: rtl/rdft_seq.sv
module rdft_seq
    import rdft_dtmf_pkg::*;
#(
    parameter int N = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic acc_en,
    output logic ld_re,
    output logic ld_out,
    output logic done
);

    localparam int CNTW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(N - 1);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        phase_e          ph;
        logic            done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.ph)
            PH_RUN: begin
                if (stb) begin
                    if (seq_q.cnt == LAST) begin
                        seq_d.cnt = '0;
                        seq_d.ph  = PH_FIN_RE;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            PH_FIN_RE: seq_d.ph = PH_FIN_IM;
            PH_FIN_IM: begin
                seq_d.ph   = PH_RUN;
                seq_d.done = 1'b1;
            end
            default: seq_d.ph = PH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{cnt: '0, ph: PH_RUN, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign acc_en = stb && (seq_q.ph == PH_RUN);
    assign ld_re  = (seq_q.ph == PH_FIN_RE);
    assign ld_out = (seq_q.ph == PH_FIN_IM);
    assign done   = seq_q.done;

    AST_FIN_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (seq_q.ph != PH_RUN) |=> $stable(seq_q.cnt)); // R7

    AST_FIN_ORDER: assert property (@(posedge clk) disable iff (rst)
        ld_re |=> ld_out); // R5

endmodule

// File: rtl/rdft_bin.sv
module rdft_bin
    import rdft_dtmf_pkg::*;
#(
    parameter int XW    = 12,
    parameter int SW    = 24,
    parameter int COS_C = 16384,
    parameter int SIN_C = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_en,
    input  logic                 ld_re,
    input  logic                 ld_out,
    input  logic signed [XW-1:0] x,
    output logic signed [SW-1:0] re,
    output logic signed [SW-1:0] im
);

    localparam int MW = SW + COEF_W;
    localparam int UW = MW + 1;
    localparam logic signed [COEF_W-1:0] CQ = COEF_W'(COS_C);
    localparam logic signed [COEF_W-1:0] SQ = COEF_W'(SIN_C);

    typedef struct packed {
        logic signed [SW-1:0] s1;
        logic signed [SW-1:0] s2;
        logic signed [SW-1:0] re_tmp;
        logic signed [SW-1:0] re;
        logic signed [SW-1:0] im;
    } bin_t;

    bin_t bin_d, bin_q;

    logic signed [COEF_W-1:0] coef;
    logic signed [MW-1:0]     prod;
    logic signed [UW-1:0]     upd;
    logic signed [MW-1:0]     re_w;
    logic signed [MW-1:0]     prod_q14;

    always_comb begin
        // one multiplier: cos for update and real part, sin for imaginary part
        coef     = ld_out ? SQ : CQ;
        prod     = MW'(bin_q.s1) * MW'(coef);
        prod_q14 = prod >>> COEF_FRAC;
        upd      = UW'(x) + UW'(prod >>> (COEF_FRAC - 1)) - UW'(bin_q.s2);
        re_w     = prod_q14 - MW'(bin_q.s2);

        bin_d = bin_q;
        if (acc_en) begin
            bin_d.s2 = bin_q.s1;
            bin_d.s1 = upd[SW-1:0];
        end
        if (ld_re) begin
            bin_d.re_tmp = re_w[SW-1:0];
        end
        if (ld_out) begin
            bin_d.re = bin_q.re_tmp;
            bin_d.im = prod_q14[SW-1:0];
            bin_d.s1 = '0;
            bin_d.s2 = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q <= '0;
        end else begin
            bin_q <= bin_d;
        end
    end

    assign re = bin_q.re;
    assign im = bin_q.im;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        acc_en |-> ((upd[UW-1:SW-1] == '0) || (upd[UW-1:SW-1] == '1))); // R3

    AST_STATE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ld_out |=> (bin_q.s1 == '0 && bin_q.s2 == '0)); // R8

endmodule

// File: rtl/rdft_dtmf_bank.sv
module rdft_dtmf_bank
    import rdft_dtmf_pkg::*;
#(
    parameter int N  = 256,
    parameter int XW = 12,
    parameter int SW = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_vld,
    input  logic signed [XW-1:0]   smp,
    output logic [NUM_BINS*SW-1:0] re_o,
    output logic [NUM_BINS*SW-1:0] im_o,
    output logic                   done_o
);

    logic acc_en, ld_re, ld_out;

    rdft_seq #(.N(N)) i_seq (
        .clk    (clk),
        .rst    (rst),
        .stb    (smp_vld),
        .acc_en (acc_en),
        .ld_re  (ld_re),
        .ld_out (ld_out),
        .done   (done_o)
    );

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        localparam int K = bin_index(b, N);
        logic signed [SW-1:0] re_b, im_b;

        rdft_bin #(
            .XW    (XW),
            .SW    (SW),
            .COS_C (cos_q(K, N)),
            .SIN_C (sin_q(K, N))
        ) i_bin (
            .clk    (clk),
            .rst    (rst),
            .acc_en (acc_en),
            .ld_re  (ld_re),
            .ld_out (ld_out),
            .x      (smp),
            .re     (re_b),
            .im     (im_b)
        );

        assign re_o[b*SW +: SW] = re_b;
        assign im_o[b*SW +: SW] = im_b;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(re_o) && $stable(im_o))); // R6

endmodule

// File: tb/test_rdft_dtmf_bank.sv
module test_rdft_dtmf_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 256;
    localparam int XW = 12;
    localparam int SW = 24;
    localparam int NB = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_vld = 1'b0;
    logic signed [XW-1:0] smp = '0;
    logic [NB*SW-1:0]   re_o, im_o;
    logic               done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    longint cq [NB];
    longint sq [NB];
    longint ms1 [NB];
    longint ms2 [NB];
    longint exp_re[$];
    longint exp_im[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rdft_dtmf_bank #(.N(N), .XW(XW), .SW(SW)) i_rdft_dtmf_bank (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp(smp),
        .re_o(re_o), .im_o(im_o), .done_o(done_o)
    );

    function automatic longint wrap(input longint v);
        return (v <<< (64 - SW)) >>> (64 - SW);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int gen(input int kind, input int n);
        real t;
        t = 2.0 * 3.14159265358979 * real'(n) / 8000.0;
        case (kind)
            0: return int'(900.0 * $cos(770.0 * t) + 900.0 * $cos(1336.0 * t));
            1: return 2047;
            2: return (n == 0) ? -2048 : 0;
            3: return (n % 2 == 0) ? 2047 : -2048;
            default: return int'(1000.0 * $sin(697.0 * t) + 1000.0 * $cos(1633.0 * t));
        endcase
    endfunction

    // R3 model step
    task automatic model_step(input int v);
        for (int i = 0; i < NB; i++) begin
            longint p, s;
            p = ms1[i] * cq[i];
            s = wrap(longint'(v) + (p >>> 13) - ms2[i]);
            ms2[i] = ms1[i];
            ms1[i] = s;
        end
    endtask

    // R4 expected results
    task automatic model_finish();
        for (int i = 0; i < NB; i++) begin
            exp_re.push_back(wrap(((ms1[i] * cq[i]) >>> 14) - ms2[i]));
            exp_im.push_back(wrap((ms1[i] * sq[i]) >>> 14));
        end
    endtask

    task automatic put(input int v);
        smp = XW'(v);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_block(input int kind, input bit junk);
        int v;
        for (int i = 0; i < NB; i++) begin ms1[i] = 0; ms2[i] = 0; end  // R8 fresh state
        for (int n = 0; n < N - 1; n++) begin
            v = gen(kind, n);
            model_step(v);
            put(v);
        end
        v = gen(kind, N - 1);
        model_step(v);
        model_finish();
        smp = XW'(v);
        smp_vld = 1'b1;
        @(negedge clk);
        if (junk) smp = XW'(1234); else smp_vld = 1'b0;  // R7 stray strobe in first finishing cycle
        @(negedge clk);
        check(done_o == 1'b0, "R5 early", longint'(done_o), 0);
        if (junk) smp = XW'(-777);                       // R7 stray strobe in second finishing cycle
        @(negedge clk);
        check(done_o == 1'b1, "R5 timing", longint'(done_o), 1);
        smp_vld = 1'b0;
    endtask

    // scoreboard monitor
    logic [NB*SW-1:0] prev_re, prev_im;
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                check(!prev_done, "R5 width", 1, 0);
                for (int i = 0; i < NB; i++) begin
                    longint er, ei, ar, ai;
                    if (exp_re.size() == 0) begin
                        check(1'b0, "R4 unexpected done", 1, 0);
                        break;
                    end
                    er = exp_re.pop_front();
                    ei = exp_im.pop_front();
                    ar = longint'($signed(re_o[i*SW +: SW]));
                    ai = longint'($signed(im_o[i*SW +: SW]));
                    check(ar == er, $sformatf("R4 R2 re bin%0d", i), ar, er);
                    check(ai == ei, $sformatf("R4 R2 im bin%0d", i), ai, ei);
                end
            end else if (prev_re != re_o || prev_im != im_o) begin
                check(1'b0, "R6 hold", 1, 0);
            end
            prev_done = done_o;
            prev_re = re_o;
            prev_im = im_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            int f, k;
            case (i)
                0: f = 697;  1: f = 770;  2: f = 852;  3: f = 941;
                4: f = 1209; 5: f = 1336; 6: f = 1477; default: f = 1633;
            endcase
            k = int'(real'(f) * real'(N) / 8000.0);
            cq[i] = longint'(int'($cos(2.0 * 3.14159265358979 * real'(k) / real'(N)) * 16384.0));
            sq[i] = longint'(int'($sin(2.0 * 3.14159265358979 * real'(k) / real'(N)) * 16384.0));
        end
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 done in reset", longint'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R1 done after reset", longint'(done_o), 0);
        check(re_o == '0 && im_o == '0, "R1 results zero", longint'(re_o != '0), 0);
        prev_re = re_o;
        prev_im = im_o;
        @(negedge clk);
        run_block(0, 1'b0);
        run_block(1, 1'b1);   // R7 stray strobes, then R8 start in done cycle
        run_block(2, 1'b0);   // R8 back-to-back
        run_block(3, 1'b1);
        run_block(4, 1'b0);
        repeat (6) @(negedge clk);
        check(exp_re.size() == 0, "R5 all frames reported", longint'(exp_re.size()), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule